// File: doc/BRIEF.md
# Endian-Selectable Bus-Width Matcher

This block sits between the narrow external ports of a queue and its 36-bit internal storage word. On the write side it collects one, two or four narrow transfers into a full long word and hands that word to storage. On the read side it takes one long word from storage and returns it as one, two or four narrow transfers. Each side has its own width. The order in which the parts of a long word travel is big-endian or little-endian.

The width of each side and the byte order are taken from configuration inputs. They are sampled on every clock edge while the synchronous active-low reset is held, and they are then frozen until the next reset. All four ports use a valid/ready handshake. The narrow ports carry their payload in the low bits of a 36-bit bus. Full and empty style backpressure on the narrow ports counts narrow transfers, not long words. When a side is configured at full width, that side is a wire-level pass-through.

Top module: `bus_width_matcher`

## Requirements
- R1: The width selectors and the order input are sampled only while rst_n is low. Changing them after reset has no effect on behaviour.
- R2: Width selector encoding is 2'b00 or 2'b11 for 36 bits, 2'b01 for 18 bits and 2'b10 for 9 bits. A narrow transfer occupies bits [W-1:0] of its 36-bit bus.
- R3: With cfg_little low at reset (big-endian), the first narrow transfer of a long word is its most significant part. Later transfers move toward the least significant part.
- R4: With cfg_little high at reset (little-endian), the first narrow transfer is the least significant part. Later transfers move toward the most significant part.
- R5: On the write side, wr_valid is raised only while the final part of a long word is offered on in_valid. In that cycle wr_data carries the complete assembled word. Earlier parts are accepted with in_ready high whatever wr_ready is.
- R6: On the read side, each out_valid/out_ready handshake delivers the next part of rd_data in the configured order. The bits of out_data above the narrow width are zero.
- R7: rd_ready is high only when out_ready is high and the final part of the current long word is being offered. Storage therefore gives up each long word exactly once.
- R8: A side configured at 36 bits passes valid, ready and data straight through in the same cycle, with no added latency.
- R9: While rst_n is low, in_ready, wr_valid, out_valid and rd_ready are all low. Reset discards any partly assembled word and any partly delivered word.
- R10: The bits of in_data above the configured input width are ignored.
- R11: When the final part is offered and wr_ready is low, in_ready is low. The transfer stalls without losing data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Synchronous active-low reset; configuration is sampled while it is low |
| cfg_in_sel | input | 2 | Write-side width selector |
| cfg_out_sel | input | 2 | Read-side width selector |
| cfg_little | input | 1 | Part order: 0 big-endian, 1 little-endian |
| in_valid | input | 1 | Narrow write transfer offered |
| in_ready | output | 1 | Narrow write transfer accepted |
| in_data | input | 36 | Narrow write payload, low bits used |
| wr_valid | output | 1 | Assembled long word offered to storage |
| wr_ready | input | 1 | Storage accepts the long word |
| wr_data | output | 36 | Assembled long word |
| rd_valid | input | 1 | Storage offers a long word |
| rd_ready | output | 1 | Long word consumed from storage |
| rd_data | input | 36 | Long word from storage |
| out_valid | output | 1 | Narrow read transfer offered |
| out_ready | input | 1 | Narrow read transfer accepted |
| out_data | output | 36 | Narrow read payload, upper bits zero |

## Verification
The hardest case to reach is the final write part arriving while storage is not ready. Partial parts must still be accepted while the last one is held back. The bench reaches this by running wr_ready low on a fixed period of three cycles and gaps in in_valid on a period of five, so that the stall falls on every part position in turn across all width and order settings. A second case that is hard to reach is a reset that lands midway through assembly. The bench forces it by sending two quarter-width parts, resetting, and then checking that the next word holds no leftover bytes. Every configuration run also flips the configuration pins right after reset, to show that the latched settings hold.

// File: rtl/bwm_pkg.sv
// Package: shared width-selector encoding and its decode for the bus-width matcher.
// Assumes the long word is built from a power-of-two number of equal lanes.
package bwm_pkg;

    typedef enum logic [1:0] {
        SEL_FULL    = 2'b00,
        SEL_HALF    = 2'b01,
        SEL_QUARTER = 2'b10,
        SEL_FULL_B  = 2'b11
    } width_sel_e;

    // Returns log2 of the lanes carried by one narrow transfer.
    function automatic int unsigned lg_from_sel(input logic [1:0] sel,
                                                input int unsigned log_lanes);
        case (width_sel_e'(sel))
            SEL_HALF:    return (log_lanes >= 1) ? log_lanes - 1 : 0;
            SEL_QUARTER: return (log_lanes >= 2) ? log_lanes - 2 : 0;
            default:     return log_lanes;
        endcase
    endfunction

endpackage

// File: rtl/bwm_cfg.sv
// Configuration latch: samples the width selectors and the order bit on every
// clock edge while reset is low, and holds them unchanged afterwards.
// Assumes the configuration pins are stable during the last reset cycle.
module bwm_cfg
    import bwm_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  sel_in,
    input  logic [1:0]                  sel_out,
    input  logic                        little_in,
    output logic [$clog2(LANES):0]      in_lg,
    output logic [$clog2(LANES):0]      out_lg,
    output logic                        little_q
);
    localparam int unsigned LOG_L = $clog2(LANES);
    localparam int          PW    = LOG_L + 1;

    // Capture the configuration only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_lg    <= PW'(lg_from_sel(sel_in, LOG_L));
            out_lg   <= PW'(lg_from_sel(sel_out, LOG_L));
            little_q <= little_in;
        end
    end
endmodule

// File: rtl/bwm_part_ctr.sv
// Part counter: counts narrow transfers within one long word and wraps after
// the last part. Assumes 'last' is stable between resets.
module bwm_part_ctr #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [CW-1:0] last,
    output logic [CW-1:0] cnt
);
    // Advance on each completed narrow handshake; return to zero after the last part.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (step)
            cnt <= (cnt == last) ? '0 : cnt + CW'(1);
    end
endmodule

// File: rtl/bwm_pack.sv
// Write-side packer: assembles narrow transfers into one long word. Parts
// before the last are stored in a lane register. The last part is merged
// combinationally, so the word is offered in the same cycle as that part.
// Assumes LANES is a power of two and at least 2.
module bwm_pack #(
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(LANES):0]    lg,
    input  logic                      little,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [LANE_W*LANES-1:0]   in_data,
    output logic                      wr_valid,
    input  logic                      wr_ready,
    output logic [LANE_W*LANES-1:0]   wr_data
);
    localparam int CW = $clog2(LANES);
    localparam int PW = CW + 1;

    logic [PW-1:0]                   parts;
    logic [CW-1:0]                   last;
    logic [CW-1:0]                   cnt;
    logic                            is_last;
    logic                            accept;
    logic [LANES-1:0][LANE_W-1:0]    in_lanes;
    logic [LANES-1:0][LANE_W-1:0]    acc;
    logic [LANES-1:0][LANE_W-1:0]    lane_out;
    logic [LANES-1:0]                from_in;

    assign parts    = PW'(LANES) >> lg;
    assign last     = CW'(parts - PW'(1));
    assign is_last  = (cnt == last);
    assign in_lanes = in_data;

    // Handshake: parts before the last always fit; the last one waits for storage.
    always_comb begin
        in_ready = rst_n && (is_last ? wr_ready : 1'b1);
        wr_valid = rst_n && in_valid && is_last;
        accept   = in_valid && in_ready;
    end

    bwm_part_ctr #(.CW(CW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (accept),
        .last  (last),
        .cnt   (cnt)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [PW-1:0] slot;
        logic [PW-1:0] mask;
        logic [PW-1:0] off;
        logic [PW-1:0] part_idx;

        // Map this long-word lane to its part index and its position in that part.
        always_comb begin
            slot     = PW'(l) >> lg;
            mask     = (PW'(1) << lg) - PW'(1);
            off      = PW'(l) & mask;
            part_idx = little ? slot : (parts - PW'(1) - slot);
        end

        assign from_in[l]  = (part_idx == {1'b0, cnt});
        assign lane_out[l] = from_in[l] ? in_lanes[off[CW-1:0]] : acc[l];

        // Store the lane when its part is accepted; clear it at reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                acc[l] <= '0;
            else if (accept && from_in[l])
                acc[l] <= in_lanes[off[CW-1:0]];
        end
    end

    assign wr_data = lane_out;
endmodule

// File: rtl/bwm_unpack.sv
// Read-side unpacker: presents one long word as successive narrow transfers
// taken straight from the storage output. The word is popped on the last one.
// Assumes rd_data is held while rd_valid stays high and is not popped.
module bwm_unpack #(
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(LANES):0]    lg,
    input  logic                      little,
    input  logic                      rd_valid,
    output logic                      rd_ready,
    input  logic [LANE_W*LANES-1:0]   rd_data,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [LANE_W*LANES-1:0]   out_data
);
    localparam int CW = $clog2(LANES);
    localparam int PW = CW + 1;

    logic [PW-1:0]                   parts;
    logic [PW-1:0]                   part_lanes;
    logic [PW-1:0]                   slot;
    logic [CW-1:0]                   last;
    logic [CW-1:0]                   cnt;
    logic                            is_last;
    logic                            step;
    logic [LANES-1:0][LANE_W-1:0]    rd_lanes;
    logic [LANES-1:0][LANE_W-1:0]    out_lanes;

    assign parts      = PW'(LANES) >> lg;
    assign part_lanes = PW'(1) << lg;
    assign last       = CW'(parts - PW'(1));
    assign is_last    = (cnt == last);
    assign rd_lanes   = rd_data;

    // Pick which slot of the long word the current part comes from.
    always_comb begin
        slot = little ? {1'b0, cnt} : (parts - PW'(1) - {1'b0, cnt});
    end

    // Handshake: a narrow transfer needs a stored word; the word pops on its last part.
    always_comb begin
        out_valid = rst_n && rd_valid;
        rd_ready  = rst_n && out_ready && is_last;
        step      = out_valid && out_ready;
    end

    bwm_part_ctr #(.CW(CW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .last  (last),
        .cnt   (cnt)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [PW-1:0] src;
        logic          used;

        // Route a source lane to this output lane, or zero above the narrow width.
        always_comb begin
            used = (PW'(j) < part_lanes);
            src  = (slot << lg) + PW'(j);
            out_lanes[j] = used ? rd_lanes[src[CW-1:0]] : '0;
        end
    end

    assign out_data = out_lanes;
endmodule

// File: rtl/bus_width_matcher.sv
// Top: a bus-width matcher with separate write and read widths and a
// selectable part order, all latched during synchronous active-low reset.
// Assumes storage sits between wr_* and rd_* and holds rd_data until popped.
module bus_width_matcher #(
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cfg_in_sel,
    input  logic [1:0]               cfg_out_sel,
    input  logic                     cfg_little,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [LANE_W*LANES-1:0]  in_data,
    output logic                     wr_valid,
    input  logic                     wr_ready,
    output logic [LANE_W*LANES-1:0]  wr_data,
    input  logic                     rd_valid,
    output logic                     rd_ready,
    input  logic [LANE_W*LANES-1:0]  rd_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [LANE_W*LANES-1:0]  out_data
);
    localparam int PW = $clog2(LANES) + 1;

    logic [PW-1:0] in_lg;
    logic [PW-1:0] out_lg;
    logic          little_q;

    bwm_cfg #(.LANES(LANES)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_in    (cfg_in_sel),
        .sel_out   (cfg_out_sel),
        .little_in (cfg_little),
        .in_lg     (in_lg),
        .out_lg    (out_lg),
        .little_q  (little_q)
    );

    bwm_pack #(.LANE_W(LANE_W), .LANES(LANES)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .lg       (in_lg),
        .little   (little_q),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .wr_valid (wr_valid),
        .wr_ready (wr_ready),
        .wr_data  (wr_data)
    );

    bwm_unpack #(.LANE_W(LANE_W), .LANES(LANES)) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .lg        (out_lg),
        .little    (little_q),
        .rd_valid  (rd_valid),
        .rd_ready  (rd_ready),
        .rd_data   (rd_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );
endmodule

// File: rtl/bwm_checker.sv
// Checker for the bus-width matcher: handshake, reset and configuration
// properties. It is attached to every instance of the top by the bind below.
module bwm_checker #(
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic [LANE_W*LANES-1:0]  in_data,
    input logic                     wr_valid,
    input logic                     wr_ready,
    input logic [LANE_W*LANES-1:0]  wr_data,
    input logic                     rd_ready,
    input logic                     out_valid,
    input logic                     out_ready,
    input logic [LANE_W*LANES-1:0]  out_data,
    input logic [$clog2(LANES):0]   in_lg,
    input logic [$clog2(LANES):0]   out_lg,
    input logic                     little_q
);
    localparam int CW = $clog2(LANES);

    // R1: latched configuration does not move while out of reset.
    p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable({in_lg, out_lg, little_q}));

    // R5: a long word is offered only while a narrow part is offered.
    p_word_needs_part_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> in_valid);

    // R6: bits above the narrow read width are zero.
    p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (int'(out_lg) != CW)) |-> ((out_data >> (LANE_W << out_lg)) == '0));

    // R7: storage is popped only during an accepted narrow read.
    p_pop_with_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> out_ready);

    // R8: full-width write side is a same-cycle pass-through.
    p_pass_through_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(in_lg) == CW) |-> (wr_valid == in_valid && in_ready == wr_ready && wr_data == in_data));

    // R9: all handshake outputs are quiet during reset.
    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |-> (!in_ready && !wr_valid && !out_valid && !rd_ready));

    // R11: a blocked long word holds back its final part.
    p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |-> !in_ready);
endmodule

bind bus_width_matcher bwm_checker #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_data   (wr_data),
    .rd_ready  (rd_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .in_lg     (in_lg),
    .out_lg    (out_lg),
    .little_q  (little_q)
);

// File: tb/sim_bus_width_matcher.sv
`timescale 1ns/100ps
// Bench: sweeps every width-selector pair and both part orders, with
// periodic backpressure, plus a reset in the middle of assembly.
module sim_bus_width_matcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_in_sel = 2'b00;
    logic [1:0]  cfg_out_sel = 2'b00;
    logic        cfg_little = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [35:0] in_data = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [35:0] wr_data;
    logic        rd_valid = 1'b0;
    logic        rd_ready;
    logic [35:0] rd_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [35:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    bus_width_matcher u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int lg_of(input int sel);
        return (sel == 1) ? 1 : (sel == 2) ? 0 : 2;
    endfunction

    function automatic logic [35:0] wmask(input int w);
        return (w >= 36) ? {36{1'b1}} : ((36'h1 << w) - 36'h1);
    endfunction

    function automatic logic [35:0] mkword(input int c, input int w);
        logic [35:0] v;
        for (int l = 0; l < 4; l++) v[l*9 +: 9] = 9'((c * 29 + w * 71 + l * 3 + 1) % 512);
        return v;
    endfunction

    function automatic logic [35:0] part_of(input logic [35:0] word, input int lg, input bit little, input int k);
        int parts = 4 >> lg;
        int w     = 9 << lg;
        int slot  = little ? k : parts - 1 - k;
        return (word >> (slot * w)) & wmask(w);
    endfunction

    task automatic do_reset(input int isel, input int osel, input bit little);
        @(negedge clk);
        rst_n = 1'b0; cfg_in_sel = 2'(isel); cfg_out_sel = 2'(osel); cfg_little = little;
        in_valid = 1'b1; rd_valid = 1'b1; wr_ready = 1'b1; out_ready = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk(!in_ready && !wr_valid && !out_valid && !rd_ready, "R9 quiet in reset",
            {32'd0, in_ready, wr_valid, out_valid, rd_ready}, 36'd0);
        @(negedge clk);
        rst_n = 1'b1; in_valid = 1'b0; rd_valid = 1'b0;
        // R1: scramble configuration pins once out of reset.
        cfg_in_sel = ~cfg_in_sel; cfg_out_sel = ~cfg_out_sel; cfg_little = ~cfg_little;
    endtask

    task automatic pack_run(input int c, input int lg, input bit little, input int nwords);
        int parts = 4 >> lg;
        int k = 0;
        int w = 0;
        int cyc = 0;
        logic [35:0] word;
        string tag;
        tag = (lg == 2) ? "R8 write pass-through (R1 R2)" :
              little ? "R4 little-endian pack (R1 R2 R10)" : "R3 big-endian pack (R1 R2 R10)";
        while (w < nwords) begin
            @(negedge clk);
            word     = mkword(c, w);
            in_valid = (cyc % 5) != 4;
            wr_ready = (cyc % 3) != 2;
            in_data  = part_of(word, lg, little, k) | (~wmask(9 << lg) & 36'hA5A5A5A5A);
            #1;
            if (!in_valid) begin
                chk(!wr_valid, "R5 no word without part", {35'd0, wr_valid}, 36'd0);
            end else if (k == parts - 1) begin
                chk(wr_valid, "R5 word on final part", {35'd0, wr_valid}, 36'd1);
                chk(in_ready == wr_ready, "R11 final part follows wr_ready", {35'd0, in_ready}, {35'd0, wr_ready});
                if (wr_ready) chk(wr_data == word, tag, wr_data, word);
                if (wr_ready) begin k = 0; w++; end
            end else begin
                chk(!wr_valid && in_ready, "R5 partial accepted without word",
                    {34'd0, wr_valid, in_ready}, 36'd1);
                k++;
            end
            cyc++;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic unpack_run(input int c, input int lg, input bit little, input int nwords);
        int parts = 4 >> lg;
        int k = 0;
        int w = 0;
        int cyc = 0;
        logic [35:0] word;
        logic [35:0] exp;
        string tag;
        tag = (lg == 2) ? "R8 read pass-through (R1 R2)" :
              little ? "R6 little-endian unpack (R4)" : "R6 big-endian unpack (R3)";
        while (w < nwords) begin
            @(negedge clk);
            word      = mkword(c + 40, w);
            rd_valid  = 1'b1;
            rd_data   = word;
            out_ready = (cyc % 4) != 3;
            #1;
            chk(out_valid, "R6 read offered", {35'd0, out_valid}, 36'd1);
            chk(rd_ready == (out_ready && k == parts - 1), "R7 pop only on last part",
                {35'd0, rd_ready}, {35'd0, (out_ready && k == parts - 1)});
            if (out_ready) begin
                exp = part_of(word, lg, little, k);
                chk(out_data == exp, tag, out_data, exp);
                k++;
                if (k == parts) begin k = 0; w++; end
            end
            cyc++;
        end
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    initial begin
        logic [35:0] wa;
        logic [35:0] wb;
        for (int isel = 0; isel < 4; isel++) begin
            for (int osel = 0; osel < 4; osel++) begin
                for (int le = 0; le < 2; le++) begin
                    int c = isel * 8 + osel * 2 + le;
                    do_reset(isel, osel, bit'(le));
                    pack_run(c, lg_of(isel), bit'(le), 4);
                    unpack_run(c, lg_of(osel), bit'(le), 4);
                end
            end
        end
        // R9: reset in the middle of a quarter-width big-endian word.
        do_reset(2, 2, 1'b0);
        wa = 36'h123456789;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            in_valid = 1'b1; wr_ready = 1'b1;
            in_data  = part_of(wa, 0, 1'b0, k);
        end
        do_reset(2, 2, 1'b0);
        wb = 36'hFEDCBA987;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid = 1'b1; wr_ready = 1'b1;
            in_data  = part_of(wb, 0, 1'b0, k);
            #1;
            if (k == 3) chk(wr_valid && wr_data == wb, "R9 partial word discarded by reset", wr_data, wb);
        end
        @(negedge clk);
        in_valid = 1'b0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 36'd0, 36'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule